// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a single asynchronous serial input line into parallel characters. A sampling enable, supplied from outside, pulses at 16 or 8 times the bit rate. A mode input chooses between the two ratios while the block is running. The line is resynchronized to the block clock. A falling edge is taken as a start bit only after a run of consecutive low samples. Shorter low pulses are discarded as noise.

After a start is confirmed, the block samples each data bit, an optional parity bit and one stop bit near the centre of each bit. It then presents the character right-justified, together with parity-error and framing-error flags and a one-cycle valid pulse. Character length, bit order and parity mode come from configuration inputs. An acknowledge input marks the character as read. A character that completes before the previous one was acknowledged raises an overrun flag. The receiver checks only one stop bit. It begins hunting for the next start as soon as that stop bit is sampled, so characters sent back to back with a single stop bit are received without loss.

Top module: `async_rx`

## Requirements
- R1: With `os8`=0 (16x), a start is accepted only after 8 consecutive low samples of the synchronized line on `tick` cycles.
- R2: With `os8`=1 (8x), a start is accepted only after 4 consecutive low samples.
- R3: A high sample before the required low run is complete rejects the start. The block returns to idle hunting, and no character is produced.
- R4: After acceptance, every following bit is sampled once every 16 ticks (16x) or every 8 ticks (8x).
- R5: `len_sel` 0,1,2,3,4 selects 5,6,7,8,9 data bits. `rx_data` is right-justified with the unused upper bits zero.
- R6: `msb_first`=0 takes the first received data bit as bit 0. `msb_first`=1 takes it as the top bit of the character.
- R7: `par_mode` 0 means no parity bit, 1 even, 2 odd, 3 parity bit forced 0, 4 parity bit forced 1. `parity_err` is 1 when the received parity bit differs from the expected value.
- R8: Only one stop bit is checked. `frame_err` is 1 when it is sampled 0. Start hunting resumes right after the stop sample, so back-to-back characters are all received.
- R9: `rx_valid` is a one-cycle pulse issued when the stop bit is sampled. `rx_data` and the flags hold until the next character.
- R10: `overrun` is set when a character completes while the previous one is still unacknowledged. A `rd_ack` pulse clears `overrun` and marks the character as read.
- R11: After reset, `rx_valid`, `rx_data`, `parity_err`, `frame_err` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sampling enable at 16x or 8x the bit rate |
| os8 | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| rxd | input | 1 | Asynchronous serial input, idle high |
| len_sel | input | 3 | Data length code (5 to 9 bits) |
| msb_first | input | 1 | Bit order of received data |
| par_mode | input | 3 | Parity mode code |
| rd_ack | input | 1 | Marks the current character as read |
| rx_data | output | 9 | Received character, right-justified |
| rx_valid | output | 1 | One-cycle pulse per received character |
| parity_err | output | 1 | Parity mismatch on the current character |
| frame_err | output | 1 | Stop bit sampled low on the current character |
| overrun | output | 1 | A character was lost before being acknowledged |

## Verification
The assertions assume that `tick` never comes faster than once per clock. They also assume that `os8`, `len_sel`, `msb_first` and `par_mode` stay constant while a character is in flight, because the sample spacing and the bit count are read every tick. The stimulus follows these rules. Configuration changes only between characters while the line is idle. `tick` runs at every second clock, and each serial bit lasts exactly the oversampling ratio in ticks. A frame with a bad stop bit holds that bit low for only three quarters of a bit, so the remaining low time stays below the start-qualification run.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_BITS} rx_state_t;
  localparam logic [2:0] PAR_NONE = 3'd0;
  localparam logic [2:0] PAR_EVEN = 3'd1;
  localparam logic [2:0] PAR_ODD  = 3'd2;
  localparam logic [2:0] PAR_ZERO = 3'd3;
  localparam logic [2:0] PAR_ONE  = 3'd4;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;
  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], d};
  end
  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rx_timing.sv
module rx_timing
  import async_rx_pkg::*;
#(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          os8,
  input  logic          rxs,
  input  logic [IW-1:0] frame_len,
  output logic          samp,
  output logic          sbit,
  output logic [IW-1:0] sidx
);
  localparam int CW = $clog2(OS_HI);

  rx_state_t     state;
  logic [CW:0]   cnt;
  logic [CW:0]   full;
  logic [CW:0]   half;
  logic [IW-1:0] idx;

  assign full = os8 ? OS_LO[CW:0] : OS_HI[CW:0];
  assign half = full >> 1;

  always_ff @(posedge clk) begin
    samp <= 1'b0;
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sbit  <= 1'b1;
      sidx  <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!rxs) begin
            cnt   <= {{CW{1'b0}}, 1'b1};
            state <= ST_HUNT;
          end
        end
        ST_HUNT: begin
          if (rxs) begin
            state <= ST_IDLE;
          end else if (cnt == half - 1'b1) begin
            state <= ST_BITS;
            cnt   <= '0;
            idx   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == full - 1'b1) begin
            cnt  <= '0;
            samp <= 1'b1;
            sbit <= rxs;
            sidx <= idx;
            idx  <= idx + 1'b1;
            if (idx == frame_len - 1'b1) state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R3
  reject_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HUNT && tick && rxs) |=> (state == ST_IDLE));
  // R4
  spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITS) |-> (cnt < full));
  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (samp && sidx == frame_len - 1'b1) |-> (state == ST_IDLE));
endmodule

// File: rtl/rx_assemble.sv
module rx_assemble
  import async_rx_pkg::*;
#(
  parameter int MAXB = 9,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            samp,
  input  logic            sbit,
  input  logic [IW-1:0]   sidx,
  input  logic [IW-1:0]   nbits,
  input  logic            has_par,
  input  logic            msb_first,
  input  logic [2:0]      par_mode,
  input  logic            rd_ack,
  output logic [MAXB-1:0] rx_data,
  output logic            rx_valid,
  output logic            parity_err,
  output logic            frame_err,
  output logic            overrun
);
  logic [MAXB-1:0] sh;
  logic            par_acc;
  logic            par_bit;
  logic            unread;
  logic            par_exp;
  logic [MAXB-1:0] lsb_val;

  assign lsb_val = sh >> (IW'(MAXB) - nbits);

  always_comb begin
    case (par_mode)
      PAR_EVEN: par_exp = par_acc;
      PAR_ODD:  par_exp = ~par_acc;
      PAR_ONE:  par_exp = 1'b1;
      default:  par_exp = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    rx_valid <= 1'b0;
    if (rst) begin
      sh         <= '0;
      par_acc    <= 1'b0;
      par_bit    <= 1'b0;
      unread     <= 1'b0;
      rx_data    <= '0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (rd_ack) begin
        unread  <= 1'b0;
        overrun <= 1'b0;
      end
      if (samp) begin
        if (sidx < nbits) begin
          sh      <= msb_first ? {sh[MAXB-2:0], sbit} : {sbit, sh[MAXB-1:1]};
          par_acc <= par_acc ^ sbit;
        end else if (has_par && sidx == nbits) begin
          par_bit <= sbit;
        end else begin
          rx_valid   <= 1'b1;
          rx_data    <= msb_first ? sh : lsb_val;
          frame_err  <= ~sbit;
          parity_err <= has_par && (par_bit != par_exp);
          unread     <= 1'b1;
          if (unread && !rd_ack) overrun <= 1'b1;
          sh         <= '0;
          par_acc    <= 1'b0;
        end
      end
    end
  end

  // R9
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R9
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(samp));
  // R10
  overrun_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> rx_valid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data));
endmodule

// File: rtl/async_rx.sv
module async_rx #(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8,
  parameter int MAXB  = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            os8,
  input  logic            rxd,
  input  logic [2:0]      len_sel,
  input  logic            msb_first,
  input  logic [2:0]      par_mode,
  input  logic            rd_ack,
  output logic [MAXB-1:0] rx_data,
  output logic            rx_valid,
  output logic            parity_err,
  output logic            frame_err,
  output logic            overrun
);
  localparam int IW = $clog2(MAXB + 3);

  logic          rxs;
  logic          samp;
  logic          sbit;
  logic [IW-1:0] sidx;
  logic [IW-1:0] nbits;
  logic          has_par;
  logic [IW-1:0] frame_len;

  assign nbits     = (len_sel > 3'd4) ? IW'(MAXB) : IW'(MAXB - 4) + IW'(len_sel);
  assign has_par   = (par_mode != 3'd0) && (par_mode <= 3'd4);
  assign frame_len = nbits + IW'(has_par) + 1'b1;

  rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(rxs)
  );

  rx_timing #(.OS_HI(OS_HI), .OS_LO(OS_LO), .IW(IW)) u_timing (
    .clk(clk), .rst(rst), .tick(tick), .os8(os8), .rxs(rxs),
    .frame_len(frame_len), .samp(samp), .sbit(sbit), .sidx(sidx)
  );

  rx_assemble #(.MAXB(MAXB), .IW(IW)) u_asm (
    .clk(clk), .rst(rst), .samp(samp), .sbit(sbit), .sidx(sidx),
    .nbits(nbits), .has_par(has_par), .msb_first(msb_first),
    .par_mode(par_mode), .rd_ack(rd_ack), .rx_data(rx_data),
    .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err),
    .overrun(overrun)
  );
endmodule

// File: tb/sim_async_rx.sv
`timescale 1ns/1ps
module sim_async_rx;
  logic clk = 0, rst = 1, tick = 0, os8 = 0, rxd = 1, msb_first = 0, rd_ack = 0;
  logic [2:0] len_sel = 0, par_mode = 0;
  logic [8:0] rx_data;
  logic rx_valid, parity_err, frame_err, overrun;
  int checks = 0, errors = 0, cap_cnt = 0;
  logic [8:0] hist [0:7];
  bit done = 0;

  async_rx u0 (.clk(clk), .rst(rst), .tick(tick), .os8(os8), .rxd(rxd),
    .len_sel(len_sel), .msb_first(msb_first), .par_mode(par_mode),
    .rd_ack(rd_ack), .rx_data(rx_data), .rx_valid(rx_valid),
    .parity_err(parity_err), .frame_err(frame_err), .overrun(overrun));

  always #2.5 clk = ~clk;
  initial forever begin @(negedge clk); tick = ~tick; end

  always @(negedge clk) if (!rst && rx_valid) begin
    hist[cap_cnt % 8] = rx_data;
    cap_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitclk();
    return (os8 ? 8 : 16) * 2;
  endfunction

  task automatic hold(input bit b, input int clks);
    rxd = b;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send_char(input int d, input bit bad_par, input bit bad_stop);
    int n = 5 + int'(len_sel);
    bit pb;
    hold(0, bitclk());
    for (int i = 0; i < n; i++) hold(msb_first ? d[n-1-i] : d[i], bitclk());
    pb = 0;
    for (int i = 0; i < n; i++) pb ^= d[i];
    case (par_mode)
      3'd1: pb = pb;
      3'd2: pb = ~pb;
      3'd3: pb = 0;
      default: pb = 1;
    endcase
    if (par_mode != 0) hold(pb ^ bad_par, bitclk());
    if (bad_stop) hold(0, bitclk() * 3 / 4);
    else          hold(1, bitclk());
    rxd = 1;
  endtask

  task automatic ack();
    rd_ack = 1; @(negedge clk); rd_ack = 0;
  endtask

  task automatic run_one(input int d, input bit bad_par, input bit bad_stop, input string tag);
    int c0 = cap_cnt;
    int mask = (1 << (5 + int'(len_sel))) - 1;
    send_char(d, bad_par, bad_stop);
    hold(1, bitclk() * 2);
    chk(cap_cnt == c0 + 1, {tag, " count"}, cap_cnt - c0, 1);
    chk(int'(rx_data) == (d & mask), {tag, " data"}, rx_data, d & mask);
    chk(parity_err == bad_par && frame_err == bad_stop, {tag, " flags"},
        {parity_err, frame_err}, {bad_par, bad_stop});
    // R9: pulse is over, values held
    chk(!rx_valid && !overrun, "R9 R10 idle after char", {rx_valid, overrun}, 0);
    ack();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c0, d;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11
    chk(rx_valid == 0 && rx_data == 0 && parity_err == 0 && frame_err == 0 && overrun == 0,
        "R11 reset", {rx_valid, rx_data, parity_err, frame_err, overrun}, 0);

    // R1 R2 R4 R5 R6 R7 R8: sweep of every configuration at both ratios
    for (int o = 0; o < 2; o++)
      for (int l = 0; l < 5; l++)
        for (int m = 0; m < 2; m++)
          for (int p = 0; p < 5; p++) begin
            os8 = o[0]; len_sel = l[2:0]; msb_first = m[0]; par_mode = p[2:0];
            d = (l * 73 + p * 29 + m * 7 + o * 13 + 5) & 9'h1ff;
            run_one(d, 0, 0, "R1 R2 R4 R5 R6 good");
            if (p != 0) run_one(d ^ 9'h0a5, 1, 0, "R7 bad parity");
            else        run_one(d ^ 9'h15a, 0, 1, "R8 bad stop");
          end

    // R8: back-to-back characters with a single stop bit
    for (int o = 0; o < 2; o++) begin
      os8 = o[0]; len_sel = 3; msb_first = 0; par_mode = 1;
      c0 = cap_cnt;
      send_char(8'h3c, 0, 0); send_char(8'hc3, 0, 0); send_char(8'h5a, 0, 0);
      hold(1, bitclk() * 2);
      chk(cap_cnt == c0 + 3, "R8 back-to-back count", cap_cnt - c0, 3);
      chk(hist[c0 % 8] == 9'h3c && hist[(c0 + 1) % 8] == 9'hc3 && hist[(c0 + 2) % 8] == 9'h5a,
          "R8 back-to-back data", hist[(c0 + 2) % 8], 9'h5a);
      ack();
    end

    // R3 R1: 6-tick glitch is under the 8-sample run at 16x
    os8 = 0; len_sel = 3; par_mode = 0; msb_first = 0;
    c0 = cap_cnt;
    hold(0, 12); hold(1, bitclk() * 3);
    chk(cap_cnt == c0 && !rx_valid, "R3 R1 glitch 16x", cap_cnt - c0, 0);
    run_one(9'h96, 0, 0, "R3 resync 16x");
    // R3 R2: 2-tick glitch at 8x
    os8 = 1;
    c0 = cap_cnt;
    hold(0, 4); hold(1, bitclk() * 3);
    chk(cap_cnt == c0 && !rx_valid, "R3 R2 glitch 8x", cap_cnt - c0, 0);
    run_one(9'h69, 0, 0, "R3 resync 8x");

    // R10: overrun when a second character arrives unacknowledged
    send_char(8'h11, 0, 0); hold(1, bitclk());
    chk(overrun == 0, "R10 first char", overrun, 0);
    send_char(8'h22, 0, 0); hold(1, bitclk());
    chk(overrun == 1, "R10 overrun set", overrun, 1);
    chk(rx_data == 9'h22, "R10 newest data", rx_data, 9'h22);
    ack(); @(negedge clk);
    chk(overrun == 0, "R10 ack clears", overrun, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule